// File: doc/BRIEF.md
# Interrupt and Error Status Unit

This unit holds the interrupt and error reporting registers of an entropy distribution peripheral. The registers sit on a simple 32-bit bus that has only a write strobe, an address and write data, plus combinational read data for whichever address is presented. Two interrupt sources are supported: command-done and fatal-error. Each source has a state bit, an enable bit and a test bit. Each interrupt line is driven high while its state bit and its enable bit are both set.

A write-only alert-test register fires single-cycle alert pulses, one for a recoverable alert and one for a fatal alert. Error strobes from the FIFO and state-machine checkers land in a sticky error-code register. Software cannot write that register, and only reset clears it. An error-injection register takes a bit index and sets the matching error-code bit. Injecting one of the queue or state-machine indices also raises the fatal interrupt state. Injecting one of the FIFO access indices does not.

Every pin is a plain control or status signal. None of the traffic is a data stream, so the unit has no valid/ready handshake and exerts no back-pressure.

Top module: `ent_irq_err_unit`

## Requirements
- R1: The state register at offset 0x00 holds command-done in bit 0 and fatal-error in bit 1. A high `cmd_done_evt_i` sets bit 0 and a high `fatal_evt_i` sets bit 1. Writing 1 to a bit clears it. A set in the same cycle as a clear wins.
- R2: The enable register at offset 0x04 stores bits 1:0 from a write and reads them back. All other bits read 0.
- R3: Writing 1 to a bit of the test register at offset 0x08 sets the state bit at the same position. The test register reads 0.
- R4: `irq_cmd_done_o` equals state bit 0 AND enable bit 0, and `irq_fatal_o` equals state bit 1 AND enable bit 1. Both take effect in the cycle after the write or event.
- R5: A write to offset 0x0C with bit 0 set drives `alert_recov_o` high for exactly the following cycle. Bit 1 does the same for `alert_fatal_o`. Each write gives one pulse, and the register reads 0.
- R6: The error-code register at offset 0x38 uses these bit positions: 0 reseed queue, 1 generate queue, 2 output queue, 20 acknowledge state machine, 21 main state machine, 22 hardened counter, 28 FIFO write, 29 FIFO read, 30 FIFO state. `err_evt_i[k]` sets the k-th position in that order. The bits are sticky, writes to them have no effect, and only reset clears them.
- R7: A write to the injection register at offset 0x3C takes an index from bits 4:0. If the index is one of the R6 positions, that error bit is set. Any other index has no effect. The register reads 0.
- R8: Injecting index 0, 1, 2, 20, 21 or 22 also sets fatal state bit 1. Injecting 28, 29 or 30 leaves it unchanged.
- R9: After reset every readable register reads 0, and all interrupt and alert outputs are low.
- R10: A write to any other offset changes no state, and a read from any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register byte offset |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for `bus_addr_i` (combinational) |
| cmd_done_evt_i | input | 1 | Command-done strobe from the sequencer |
| fatal_evt_i | input | 1 | Fatal-error strobe |
| err_evt_i | input | 9 | Error strobes, in R6 order |
| irq_cmd_done_o | output | 1 | Command-done interrupt |
| irq_fatal_o | output | 1 | Fatal-error interrupt |
| alert_recov_o | output | 1 | Recoverable alert pulse |
| alert_fatal_o | output | 1 | Fatal alert pulse |

## Verification
The bench builds the unit with its default parameters, an 8-bit address and a 32-bit data path. At that size every injection index from 0 to 31 can be swept from a fresh reset, with the expected error-code word and the fatal state worked out from the index. All sixteen combinations of state and enable are walked through, and so are all four alert-test patterns and each of the nine error strobes. The same-cycle collision between a hardware set and a write-one-to-clear is checked on its own.

// File: rtl/ent_irq_pkg.sv
package ent_irq_pkg;
  localparam int NUM_IRQ = 2;
  localparam int NUM_ALERT = 2;
  localparam int NUM_ERR = 9;
  localparam int IDX_W = 5;

  localparam logic [7:0] OFF_STATE  = 8'h00;
  localparam logic [7:0] OFF_ENABLE = 8'h04;
  localparam logic [7:0] OFF_TEST   = 8'h08;
  localparam logic [7:0] OFF_ALERT  = 8'h0C;
  localparam logic [7:0] OFF_ERR    = 8'h38;
  localparam logic [7:0] OFF_INJ    = 8'h3C;

  // bit position of the k-th error source in the error-code word
  function automatic int err_pos(input int k);
    case (k)
      0: return 0;
      1: return 1;
      2: return 2;
      3: return 20;
      4: return 21;
      5: return 22;
      6: return 28;
      7: return 29;
      default: return 30;
    endcase
  endfunction

  function automatic logic inj_is_fatal(input logic [IDX_W-1:0] idx);
    return (idx <= 5'd2) || (idx >= 5'd20 && idx <= 5'd22);
  endfunction
endpackage

// File: rtl/ent_irq_bank.sv
module ent_irq_bank #(
  parameter int N = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      hw_set_i,
  input  logic              wr_state_i,
  input  logic              wr_en_i,
  input  logic              wr_test_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [N-1:0]      state_o,
  output logic [N-1:0]      en_o,
  output logic [N-1:0]      irq_o
);
  for (genvar i = 0; i < N; i++) begin : g_src
    logic set_now;
    assign set_now = hw_set_i[i] || (wr_test_i && wdata_i[i]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        state_o[i] <= 1'b0;
        en_o[i]    <= 1'b0;
      end else begin
        if (set_now)
          state_o[i] <= 1'b1;
        else if (wr_state_i && wdata_i[i])
          state_o[i] <= 1'b0;
        if (wr_en_i)
          en_o[i] <= wdata_i[i];
      end
    end

    assign irq_o[i] = state_o[i] & en_o[i];

    AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_state_i && wdata_i[i] && !hw_set_i[i] && !(wr_test_i && wdata_i[i])) |=> !state_o[i]); // R1
    AST_HW_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hw_set_i[i] |=> state_o[i]); // R1
    AST_TEST_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_test_i && wdata_i[i]) |=> state_o[i]); // R3
  end
endmodule

// File: rtl/ent_alert_pulse.sv
module ent_alert_pulse #(
  parameter int N = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [N-1:0]      pulse_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pulse_o <= '0;
    else if (fire_i) pulse_o <= wdata_i[N-1:0];
    else             pulse_o <= '0;
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_ALERT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pulse_o[i] && !(fire_i && wdata_i[i])) |=> !pulse_o[i]); // R5
  end
endmodule

// File: rtl/ent_err_status.sv
module ent_err_status
  import ent_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_ERR-1:0] err_evt_i,
  input  logic               inj_we_i,
  input  logic [IDX_W-1:0]   inj_idx_i,
  output logic [DATA_W-1:0]  code_o,
  output logic               inj_fatal_o
);
  logic [NUM_ERR-1:0] bits_q;

  for (genvar k = 0; k < NUM_ERR; k++) begin : g_err
    localparam int P = err_pos(k);
    logic hit;
    assign hit = err_evt_i[k] || (inj_we_i && (inj_idx_i == IDX_W'(P)));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  bits_q[k] <= 1'b0;
      else if (hit) bits_q[k] <= 1'b1;
    end

    AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bits_q[k] |=> bits_q[k]); // R6
    AST_INJ_SETS_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inj_we_i && inj_idx_i == IDX_W'(P)) |=> bits_q[k]); // R7
  end

  always_comb begin
    code_o = '0;
    for (int k = 0; k < NUM_ERR; k++) code_o[err_pos(k)] = bits_q[k];
  end

  assign inj_fatal_o = inj_we_i && inj_is_fatal(inj_idx_i);
endmodule

// File: rtl/ent_irq_err_unit.sv
module ent_irq_err_unit
  import ent_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_we_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  input  logic               cmd_done_evt_i,
  input  logic               fatal_evt_i,
  input  logic [NUM_ERR-1:0] err_evt_i,
  output logic               irq_cmd_done_o,
  output logic               irq_fatal_o,
  output logic               alert_recov_o,
  output logic               alert_fatal_o
);
  logic sel_state, sel_en, sel_test, sel_alert, sel_err, sel_inj;
  assign sel_state = bus_addr_i == ADDR_W'(OFF_STATE);
  assign sel_en    = bus_addr_i == ADDR_W'(OFF_ENABLE);
  assign sel_test  = bus_addr_i == ADDR_W'(OFF_TEST);
  assign sel_alert = bus_addr_i == ADDR_W'(OFF_ALERT);
  assign sel_err   = bus_addr_i == ADDR_W'(OFF_ERR);
  assign sel_inj   = bus_addr_i == ADDR_W'(OFF_INJ);

  logic [NUM_IRQ-1:0]   st, en, irq, hw_set;
  logic [NUM_ALERT-1:0] alert;
  logic [DATA_W-1:0]    code;
  logic                 inj_fatal;

  ent_err_status #(.DATA_W(DATA_W)) u_err (
    .clk_i, .rst_ni,
    .err_evt_i   (err_evt_i),
    .inj_we_i    (bus_we_i && sel_inj),
    .inj_idx_i   (bus_wdata_i[IDX_W-1:0]),
    .code_o      (code),
    .inj_fatal_o (inj_fatal)
  );

  assign hw_set = {fatal_evt_i || inj_fatal, cmd_done_evt_i};

  ent_irq_bank #(.N(NUM_IRQ), .DATA_W(DATA_W)) u_irq (
    .clk_i, .rst_ni,
    .hw_set_i   (hw_set),
    .wr_state_i (bus_we_i && sel_state),
    .wr_en_i    (bus_we_i && sel_en),
    .wr_test_i  (bus_we_i && sel_test),
    .wdata_i    (bus_wdata_i),
    .state_o    (st),
    .en_o       (en),
    .irq_o      (irq)
  );

  ent_alert_pulse #(.N(NUM_ALERT), .DATA_W(DATA_W)) u_alert (
    .clk_i, .rst_ni,
    .fire_i  (bus_we_i && sel_alert),
    .wdata_i (bus_wdata_i),
    .pulse_o (alert)
  );

  assign irq_cmd_done_o = irq[0];
  assign irq_fatal_o    = irq[1];
  assign alert_recov_o  = alert[0];
  assign alert_fatal_o  = alert[1];

  always_comb begin
    bus_rdata_o = '0;
    if (sel_state)    bus_rdata_o = DATA_W'(st);
    else if (sel_en)  bus_rdata_o = DATA_W'(en);
    else if (sel_err) bus_rdata_o = code;
  end

  AST_INJ_FATAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && sel_inj && inj_is_fatal(bus_wdata_i[IDX_W-1:0])) |=> st[1]); // R8
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && sel_en && !bus_wdata_i[1]) |=> !irq_fatal_o); // R4
endmodule

// File: tb/tb_ent_irq_err_unit.sv
module tb_ent_irq_err_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        cmd_evt = 1'b0, fat_evt = 1'b0;
  logic [8:0]  err_evt = '0;
  logic        irq_cd, irq_ft, al_rc, al_ft;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ent_irq_err_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .cmd_done_evt_i(cmd_evt),
    .fatal_evt_i(fat_evt), .err_evt_i(err_evt), .irq_cmd_done_o(irq_cd),
    .irq_fatal_o(irq_ft), .alert_recov_o(al_rc), .alert_fatal_o(al_ft));

  function automatic int pos_of(input int k);
    int t[9] = '{0, 1, 2, 20, 21, 22, 28, 29, 30};
    return t[k];
  endfunction

  function automatic bit listed(input int idx);
    for (int k = 0; k < 9; k++) if (pos_of(k) == idx) return 1;
    return 0;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  logic [31:0] v;

  initial begin
    do_reset();
    // R9 reset state
    foreach (v[i]) ;
    rd(8'h00, v); check("R9 state", v, 0);
    rd(8'h04, v); check("R9 enable", v, 0);
    rd(8'h38, v); check("R9 errcode", v, 0);
    check("R9 outputs", {irq_cd, irq_ft, al_rc, al_ft}, 0);

    // R2 enable read back
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, v); check("R2 enable all", v, 3);
    wr(8'h04, 32'h0000_0002); rd(8'h04, v); check("R2 enable bit1", v, 2);

    // R1 events set state
    wr(8'h04, 32'h3);
    cmd_evt = 1'b1; @(negedge clk); cmd_evt = 1'b0;
    rd(8'h00, v); check("R1 cmd evt", v, 1); check("R4 irq cd", irq_cd, 1);
    fat_evt = 1'b1; @(negedge clk); fat_evt = 1'b0;
    rd(8'h00, v); check("R1 fatal evt", v, 3); check("R4 irq ft", irq_ft, 1);
    // R1 write-one-to-clear bit0 only
    wr(8'h00, 32'h1); rd(8'h00, v); check("R1 w1c bit0", v, 2);
    // R1 set wins over clear in the same cycle
    cmd_evt = 1'b1; wr(8'h00, 32'h3); cmd_evt = 1'b0;
    rd(8'h00, v); check("R1 set wins", v, 1);
    wr(8'h00, 32'h3); rd(8'h00, v); check("R1 clear all", v, 0);

    // R3/R4 sweep of state x enable
    for (int s = 0; s < 4; s++) begin
      for (int e = 0; e < 4; e++) begin
        wr(8'h00, 32'h3);
        wr(8'h04, 32'(e));
        wr(8'h08, 32'(s));
        rd(8'h00, v); check("R3 test sets", v, 32'(s));
        check("R4 irq", {30'b0, irq_ft, irq_cd}, 32'(s & e));
      end
    end
    rd(8'h08, v); check("R3 test reads 0", v, 0);

    // R5 alert pulses
    for (int a = 0; a < 4; a++) begin
      wr(8'h0C, 32'(a));
      check("R5 pulse", {30'b0, al_ft, al_rc}, 32'(a));
      @(negedge clk);
      check("R5 single", {30'b0, al_ft, al_rc}, 0);
    end
    rd(8'h0C, v); check("R5 reads 0", v, 0);

    // R6 error strobes
    for (int k = 0; k < 9; k++) begin
      do_reset();
      err_evt[k] = 1'b1; @(negedge clk); err_evt = '0;
      rd(8'h38, v); check("R6 evt bit", v, 32'(1) << pos_of(k));
      wr(8'h38, 32'h0); wr(8'h38, 32'hFFFF_FFFF);
      rd(8'h38, v); check("R6 sticky", v, 32'(1) << pos_of(k));
    end

    // R7/R8 injection sweep over every index
    for (int idx = 0; idx < 32; idx++) begin
      do_reset();
      wr(8'h3C, 32'(idx) | 32'hFFFF_FFE0);
      rd(8'h38, v); check("R7 inject", v, listed(idx) ? (32'(1) << idx) : 0);
      rd(8'h00, v);
      check("R8 fatal", v, ((idx <= 2) || (idx >= 20 && idx <= 22)) ? 2 : 0);
    end
    rd(8'h3C, v); check("R7 reads 0", v, 0);

    // R10 unmapped offsets
    do_reset();
    wr(8'h04, 32'h1);
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, v); check("R10 read 0", v, 0);
    rd(8'h04, v); check("R10 enable kept", v, 1);
    rd(8'h00, v); check("R10 state kept", v, 0);
    rd(8'h38, v); check("R10 err kept", v, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule